// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block paces the start-up of a switching power converter. After the supply-good input rises, it walks a step index through a fixed staircase, one step per prescaled tick. From that index it derives a rising duty-cycle ceiling for the PWM stage and a falling set of binary-weighted current-sink branch enables for the analog soft-start network. When the staircase is complete it raises a done flag, drops every sink branch and enables frequency jitter for normal operation.

An auto-restart attempt pulses the restart input, which replays the whole staircase from step zero. If supply-good falls at any time, the sequencer returns to idle at once and waits for the supply to come back. All timing comes from the system clock through a parameterised prescaler. The default of 30000 cycles per tick gives 600 us steps from a 50 MHz clock, so the 32 steps take about 19.2 ms.

Top module: `softstart_seq`

## Requirements
- R1: While reset (rst_n low) is applied at a clock edge, and afterwards until a start, step_idx, duty_lim, sink_en, ss_done and jitter_en are all zero.
- R2: The sequencer stays idle, with all outputs zero, for as long as supply_ok is low. The restart input has no effect while idle.
- R3: On the first edge where supply_ok is high in idle, the ramp starts at step 0. Step k (k = 1 .. NSTEPS-1) is reached exactly k*TICK_DIV clock edges after that start edge, and the index only ever increments by one or returns to zero.
- R4: ss_done rises exactly NSTEPS*TICK_DIV edges after the start edge. It then holds with step_idx at NSTEPS-1, and jitter_en equals ss_done at all times.
- R5: duty_lim is floor(step_idx*DUTY_MAX/(NSTEPS-1)) during the ramp, DUTY_MAX when done and 0 when idle. It never decreases while supply_ok stays high and no restart occurs, so it goes from 0 at the start to DUTY_MAX at the end.
- R6: sink_en is a binary-weighted code in which bit i enables a branch of weight 2^i. During the ramp it equals (NSTEPS-1) - step_idx. It is 0 when idle and 0 when done, so the sink is fully released at the end.
- R7: A restart pulse sampled high while supply_ok is high, during the ramp or after done, reloads step 0, clears ss_done and restarts the tick interval. The next step follows TICK_DIV edges later.
- R8: If supply_ok is sampled low at any edge, the next outputs are the idle values of R1. A later rise of supply_ok starts a fresh ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above turn-on threshold (synchronous) |
| restart | input | 1 | Auto-restart request, re-runs the staircase |
| step_idx | output | STEP_W | Current staircase step |
| duty_lim | output | DUTY_W | Duty-cycle ceiling for the PWM stage |
| sink_en | output | STEP_W | Binary-weighted soft-start sink branch enables |
| ss_done | output | 1 | Soft start complete |
| jitter_en | output | 1 | Enables oscillator frequency jitter (normal mode) |

## Verification
A wrong step count or a mistimed prescaler shows on step_idx and duty_lim within one tick interval, because every step boundary is checked at its exact edge. A corrupted state register shows as sink branches still enabled while done is high, or as done arriving early or late at the end of the staircase. A restart or supply loss that fails to clear the state shows on the very next edge, as a non-zero index or a done flag that is still set.

// File: rtl/ss_pkg.sv
// Shared types for the soft-start sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ss_pkg;

    // Sequencer phase
    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_RAMP = 2'd1,
        SS_DONE = 2'd2
    } ss_state_t;

endpackage

// File: rtl/ss_prescaler.sv
// Tick prescaler: emits a one-cycle tick every TICK_DIV enabled cycles.
// Assumes: TICK_DIV >= 2. The count clears whenever run is low, so the
// first tick after run rises comes TICK_DIV cycles later.
module ss_prescaler #(
    parameter int TICK_DIV = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TICK_W = $clog2(TICK_DIV);
    localparam logic [TICK_W-1:0] LAST = TICK_W'(TICK_DIV - 1);

    logic [TICK_W-1:0] cnt;

    // Purpose: count enabled cycles and wrap at the interval end
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Purpose: flag the last cycle of each interval
    always_comb begin
        tick = run && (cnt == LAST);
    end
endmodule

// File: rtl/ss_step_ctrl.sv
// Step controller: phase state and staircase index.
// Assumes: supply_ok and restart are synchronous to clk. Supply loss has
// priority over restart, and restart over tick.
module ss_step_ctrl
    import ss_pkg::*;
#(
    parameter int NSTEPS = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      supply_ok,
    input  logic                      restart,
    input  logic                      tick,
    output ss_state_t                 state,
    output logic [$clog2(NSTEPS)-1:0] step
);
    localparam int STEP_W = $clog2(NSTEPS);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NSTEPS - 1);

    // Purpose: advance phase and index on ticks, reload on restart
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            state <= SS_IDLE;
            step  <= '0;
        end else begin
            case (state)
                SS_IDLE: begin
                    state <= SS_RAMP;
                    step  <= '0;
                end
                SS_RAMP: begin
                    if (restart) begin
                        step <= '0;
                    end else if (tick) begin
                        if (step == STEP_LAST) begin
                            state <= SS_DONE;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                end
                SS_DONE: begin
                    if (restart) begin
                        state <= SS_RAMP;
                        step  <= '0;
                    end
                end
                default: begin
                    state <= SS_IDLE;
                    step  <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ss_code_map.sv
// Code mapper: turns phase and index into the duty ceiling and the
// binary-weighted sink enables.
// Assumes: NSTEPS is a power of two, so the per-bit inversion equals
// (NSTEPS-1) - step.
module ss_code_map
    import ss_pkg::*;
#(
    parameter int NSTEPS   = 32,
    parameter int DUTY_W   = 8,
    parameter int DUTY_MAX = 192
) (
    input  ss_state_t                 state,
    input  logic [$clog2(NSTEPS)-1:0] step,
    output logic [DUTY_W-1:0]         duty,
    output logic [$clog2(NSTEPS)-1:0] sink
);
    localparam int STEP_W = $clog2(NSTEPS);
    localparam int PROD_W = STEP_W + DUTY_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;
    logic              ramping;

    // Purpose: scale the index linearly onto 0 .. DUTY_MAX
    always_comb begin
        ramping = (state == SS_RAMP);
        prod    = PROD_W'(step) * PROD_W'(DUTY_MAX);
        quot    = prod / PROD_W'(NSTEPS - 1);
        if (state == SS_DONE) begin
            duty = DUTY_W'(DUTY_MAX);
        end else if (ramping) begin
            duty = quot[DUTY_W-1:0];
        end else begin
            duty = '0;
        end
    end

    // Purpose: each sink branch stays on while its index bit is clear
    for (genvar i = 0; i < STEP_W; i++) begin : g_sink
        assign sink[i] = ramping && !step[i];
    end
endmodule

// File: rtl/softstart_seq.sv
// Stepped soft-start sequencer top.
// Assumes: synchronous inputs, synchronous active-low reset and
// NSTEPS a power of two.
module softstart_seq
    import ss_pkg::*;
#(
    parameter int TICK_DIV = 30000,
    parameter int NSTEPS   = 32,
    parameter int DUTY_W   = 8,
    parameter int DUTY_MAX = 192
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      supply_ok,
    input  logic                      restart,
    output logic [$clog2(NSTEPS)-1:0] step_idx,
    output logic [DUTY_W-1:0]         duty_lim,
    output logic [$clog2(NSTEPS)-1:0] sink_en,
    output logic                      ss_done,
    output logic                      jitter_en
);
    localparam int STEP_W = $clog2(NSTEPS);

    ss_state_t         state;
    logic [STEP_W-1:0] step;
    logic              tick;
    logic              run;

    // Purpose: the prescaler only runs during a ramp with no reload pending
    always_comb begin
        run = supply_ok && (state == SS_RAMP) && !restart;
    end

    ss_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    ss_step_ctrl #(.NSTEPS(NSTEPS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .restart   (restart),
        .tick      (tick),
        .state     (state),
        .step      (step)
    );

    ss_code_map #(
        .NSTEPS   (NSTEPS),
        .DUTY_W   (DUTY_W),
        .DUTY_MAX (DUTY_MAX)
    ) u_map (
        .state (state),
        .step  (step),
        .duty  (duty_lim),
        .sink  (sink_en)
    );

    // Purpose: drive the status flags from the phase
    always_comb begin
        step_idx  = step;
        ss_done   = (state == SS_DONE);
        jitter_en = (state == SS_DONE);
    end
endmodule

// File: rtl/ss_checker.sv
// Property checker for softstart_seq, attached with bind.
// Assumes: the same parameters as the bound instance.
module ss_checker #(
    parameter int NSTEPS = 32,
    parameter int DUTY_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      supply_ok,
    input logic                      restart,
    input logic [$clog2(NSTEPS)-1:0] step_idx,
    input logic [DUTY_W-1:0]         duty_lim,
    input logic [$clog2(NSTEPS)-1:0] sink_en,
    input logic                      ss_done
);
    // R3: the index moves only by +1 or back to zero
    a_r3_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (step_idx != $past(step_idx)) |->
        (step_idx == $past(step_idx) + 1'b1 || step_idx == '0));

    // R6: the sink is fully released once done
    a_r6_sink_off_done: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (sink_en == '0));

    // R5: the duty ceiling never falls during an undisturbed run
    a_r5_duty_mono: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(supply_ok) && !$past(restart)) |-> (duty_lim >= $past(duty_lim)));

    // R7: a restart with supply present reloads step 0 and clears done
    a_r7_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(restart) && $past(supply_ok)) |-> (step_idx == '0 && !ss_done));

    // R8: a supply loss returns every output to idle
    a_r8_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(supply_ok) |-> (step_idx == '0 && duty_lim == '0 &&
                               sink_en == '0 && !ss_done));
endmodule

bind softstart_seq ss_checker #(.NSTEPS(NSTEPS), .DUTY_W(DUTY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .restart   (restart),
    .step_idx  (step_idx),
    .duty_lim  (duty_lim),
    .sink_en   (sink_en),
    .ss_done   (ss_done)
);

// File: tb/softstart_seq_test.sv
// Directed bench for softstart_seq with a short tick interval.
module softstart_seq_test;
    localparam int DIV   = 5;
    localparam int NS    = 32;
    localparam int DW    = 8;
    localparam int DMAX  = 192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       restart = 1'b0;
    logic [4:0] step_idx;
    logic [7:0] duty_lim;
    logic [4:0] sink_en;
    logic       ss_done;
    logic       jitter_en;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    softstart_seq #(.TICK_DIV(DIV), .NSTEPS(NS), .DUTY_W(DW), .DUTY_MAX(DMAX)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .restart(restart),
        .step_idx(step_idx), .duty_lim(duty_lim), .sink_en(sink_en),
        .ss_done(ss_done), .jitter_en(jitter_en)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_duty(input int k);
        return (k * DMAX) / (NS - 1);
    endfunction

    task automatic check_idle(input string req);
        check({req, " step"}, int'(step_idx), 0);
        check({req, " duty"}, int'(duty_lim), 0);
        check({req, " sink"}, int'(sink_en), 0);
        check({req, " done"}, int'(ss_done), 0);
        check({req, " jitter"}, int'(jitter_en), 0);
    endtask

    task automatic check_step(input string req, input int k);
        check({req, " step"}, int'(step_idx), k);
        check({req, " duty"}, int'(duty_lim), exp_duty(k));
        check({req, " sink"}, int'(sink_en), NS - 1 - k);
        check({req, " done"}, int'(ss_done), 0);
    endtask

    // Start edge: supply_ok high at the next posedge
    task automatic start_ramp();
        supply_ok = 1'b1;
        cyc(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        supply_ok = 1'b1;
        cyc(3);
        check_idle("R1 in reset");
        supply_ok = 1'b0;
        rst_n = 1'b1;
        cyc(2);
        check_idle("R1 after reset");
    endtask

    task automatic t_idle_hold();
        restart = 1'b1;
        cyc(3);
        restart = 1'b0;
        cyc(2 * DIV);
        check_idle("R2 idle restart ignored");
    endtask

    task automatic t_full_ramp();
        start_ramp();
        check_step("R3 start", 0);
        for (int k = 1; k < NS; k++) begin
            cyc(DIV);
            check_step("R3 R5 R6 step", k);
        end
        check("R5 top duty", int'(duty_lim), DMAX);
        cyc(DIV - 1);
        check("R4 not yet done", int'(ss_done), 0);
        cyc(1);
        check("R4 done", int'(ss_done), 1);
        check("R4 jitter", int'(jitter_en), 1);
        check("R4 step held", int'(step_idx), NS - 1);
        check("R5 done duty", int'(duty_lim), DMAX);
        check("R6 sink released", int'(sink_en), 0);
        cyc(3 * DIV);
        check("R4 done holds", int'(ss_done), 1);
        check("R4 step holds", int'(step_idx), NS - 1);
    endtask

    task automatic t_restart_done();
        restart = 1'b1;
        cyc(1);
        restart = 1'b0;
        check_step("R7 restart after done", 0);
        check("R7 jitter off", int'(jitter_en), 0);
        cyc(DIV);
        check_step("R7 first step", 1);
    endtask

    task automatic t_restart_mid();
        cyc(8 * DIV);
        check_step("R3 mid", 9);
        cyc(2);
        restart = 1'b1;
        cyc(1);
        restart = 1'b0;
        check_step("R7 mid reload", 0);
        cyc(DIV - 1);
        check("R7 interval restarted", int'(step_idx), 0);
        cyc(1);
        check_step("R7 step after reload", 1);
    endtask

    task automatic t_supply_loss();
        cyc(3 * DIV);
        check_step("R8 pre-loss", 4);
        supply_ok = 1'b0;
        cyc(1);
        check_idle("R8 loss mid ramp");
        cyc(DIV);
        check_idle("R8 stays idle");
        start_ramp();
        check_step("R8 fresh start", 0);
        cyc(NS * DIV);
        check("R8 done again", int'(ss_done), 1);
        supply_ok = 1'b0;
        cyc(1);
        check_idle("R8 loss after done");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_hold();
        t_full_ramp();
        t_restart_done();
        t_restart_mid();
        t_supply_loss();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule